// File: doc/BRIEF.md
# Block Write-Protect Configuration Unit

This unit holds the write-protection settings of a serial memory whose array is split into sixteen blocks of 512 bytes each. The bus engine sends it the bytes of a configuration command, tagged with their position in the command. From these bytes the unit records a protected range, given as a first block and a number of contiguous blocks, and it records which block is the high-endurance one. The first time the range is programmed, a permanent lock is set. From then on both the range and the high-endurance choice are frozen.

The array write path presents each byte address it is about to store. For each address the unit answers whether the write may proceed. A refused byte is simply not stored. No error is raised and the transfer is not aborted, so a burst that runs across a protected boundary still writes its unprotected bytes. For reads of the configuration, the unit returns readback bytes whose upper nibble is all ones. The settings are modelled as registers that load their factory values on reset.

Top module: `wp_cfg_unit`

## Requirements
- R1: After reset, the start block is 15, the count is 0, the high-endurance block is 15 and the lock is clear. Readback of the range gives 8'hFF then 8'hF0, and every address is writable.
- R2: A command is treated as configuration only when bit 7 of its position-0 byte is 1. Bits 4..1 of that byte give the block number. Bits 6, 5 and 0 of that byte, and all of the position-1 byte, have no effect.
- R3: A position-2 byte with bit 7 = 1 and bit 6 = 0, received while unlocked, loads the start from the position-0 byte and the count from bits 3..0. It also sets the lock, including when the count is 0.
- R4: Address bits 12..9 form the block index b. A write to address A is allowed unless start ≤ b < start + count, evaluated without wrap past block 15. A count of 0 allows every address.
- R5: Once locked, further range commands change neither the start nor the count. The lock stays set until reset.
- R6: A position-2 byte with bits 7 and 6 both 0 sets the high-endurance block from the position-0 byte while unlocked. It has no effect while locked.
- R7: After a position-2 byte with bits 7 and 6 both 1, rd_byte is {4'hF, start} when rd_idx = 0 and {4'hF, count} when rd_idx = 1.
- R8: After a position-2 byte with bit 7 = 0 and bit 6 = 1, rd_byte is {4'hF, high-endurance block} for either value of rd_idx.
- R9: The write answer is combinational in wr_addr. Consecutive addresses that cross a protected boundary get independent answers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads factory defaults |
| cfg_vld | input | 1 | A command byte is present this cycle |
| cfg_pos | input | 2 | Position of the byte within the command (0, 1, 2) |
| cfg_byte | input | 8 | Command byte |
| rd_idx | input | 1 | Readback byte selector |
| rd_byte | output | 8 | Readback byte |
| wr_addr | input | 13 | Byte address offered by the array write path |
| wr_ok | output | 1 | 1 when the byte at wr_addr may be written |
| he_block | output | 4 | Current high-endurance block |
| sec_locked | output | 1 | Range setting has been programmed and is frozen |

## Verification
The hardest situation to reach from the ports is a range setting other than the one first programmed. The lock makes each range reachable only once per reset, so the stimulus resets the block before each of the 256 start/count pairs. It then probes the first and last byte of every block against the arithmetic range test, which covers ranges that would run past block 15. A dedicated sequence programs the high-endurance block, then locks, then tries to change both settings again and reads them back.

// File: rtl/wp_cfg_pkg.sv
// Package: shared widths, field positions and readback mode type for the
// write-protect configuration unit. Assumes a 13-bit byte address and
// sixteen equal blocks.
package wp_cfg_pkg;
    localparam int ADDR_W   = 13;
    localparam int BLK_W    = 4;
    localparam int NUM_BLK  = 1 << BLK_W;
    localparam int BLK_LSB  = ADDR_W - BLK_W;

    // field positions inside command bytes (decoded by the bus engine side)
    localparam int CMD_CFG_BIT = 7;   // position-0 byte: configuration marker
    localparam int CMD_BLK_LSB = 1;   // position-0 byte: block number LSB
    localparam int CMD_SEL_BIT = 7;   // position-2 byte: range(1) / endurance(0)
    localparam int CMD_RD_BIT  = 6;   // position-2 byte: read(1) / write(0)

    localparam logic [BLK_W-1:0] DFLT_START = BLK_W'(NUM_BLK - 1);
    localparam logic [BLK_W-1:0] DFLT_COUNT = '0;
    localparam logic [BLK_W-1:0] DFLT_HE    = BLK_W'(NUM_BLK - 1);

    typedef enum logic {RD_RANGE = 1'b0, RD_ENDUR = 1'b1} rd_mode_t;
endpackage

// File: rtl/wp_cmd_decode.sv
// Module: wp_cmd_decode
// Tracks one configuration command from its position-tagged bytes. It keeps
// the block number taken from the position-0 byte and, on the position-2
// byte, emits one-cycle strobes for the four command kinds.
// Assumes the bus engine presents position 0, 1, 2 in order; a position-0
// byte without the configuration marker disarms the tracker.
module wp_cmd_decode
    import wp_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_vld,
    input  logic [1:0]       cfg_pos,
    input  logic [7:0]       cfg_byte,
    output logic [BLK_W-1:0] blk_num,
    output logic [BLK_W-1:0] cnt_num,
    output logic             do_range_wr,
    output logic             do_endur_wr,
    output logic             do_range_rd,
    output logic             do_endur_rd
);
    logic armed;
    logic last_byte;

    // Arm on a marked position-0 byte, capture its block field, disarm after position 2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed   <= 1'b0;
            blk_num <= '0;
        end else if (cfg_vld && cfg_pos == 2'd0) begin
            armed   <= cfg_byte[CMD_CFG_BIT];
            blk_num <= cfg_byte[CMD_BLK_LSB +: BLK_W];
        end else if (last_byte) begin
            armed   <= 1'b0;
        end
    end

    // Decode the selector and direction bits of the final byte into strobes.
    always_comb begin
        last_byte   = cfg_vld && cfg_pos == 2'd2;
        cnt_num     = cfg_byte[BLK_W-1:0];
        do_range_wr = 1'b0;
        do_endur_wr = 1'b0;
        do_range_rd = 1'b0;
        do_endur_rd = 1'b0;
        if (last_byte && armed) begin
            unique case ({cfg_byte[CMD_SEL_BIT], cfg_byte[CMD_RD_BIT]})
                2'b10:   do_range_wr = 1'b1;
                2'b00:   do_endur_wr = 1'b1;
                2'b11:   do_range_rd = 1'b1;
                default: do_endur_rd = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/wp_cfg_regs.sv
// Module: wp_cfg_regs
// Holds the protected range, high-endurance block, one-time lock and the
// readback mode. Reset stands in for the factory state of non-volatile
// cells. Assumes strobes are single-cycle pulses from the decoder.
module wp_cfg_regs
    import wp_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BLK_W-1:0] blk_num,
    input  logic [BLK_W-1:0] cnt_num,
    input  logic             do_range_wr,
    input  logic             do_endur_wr,
    input  logic             do_range_rd,
    input  logic             do_endur_rd,
    output logic [BLK_W-1:0] start_q,
    output logic [BLK_W-1:0] count_q,
    output logic [BLK_W-1:0] he_q,
    output logic             lock_q,
    output rd_mode_t         mode_q
);
    // Range and lock: first range write is accepted and locks the setting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= DFLT_START;
            count_q <= DFLT_COUNT;
            lock_q  <= 1'b0;
        end else if (do_range_wr && !lock_q) begin
            start_q <= blk_num;
            count_q <= cnt_num;
            lock_q  <= 1'b1;
        end
    end

    // High-endurance block: writable only while the range is unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            he_q <= DFLT_HE;
        else if (do_endur_wr && !lock_q)
            he_q <= blk_num;
    end

    // Readback mode follows the most recent read command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= RD_RANGE;
        else if (do_range_rd)
            mode_q <= RD_RANGE;
        else if (do_endur_rd)
            mode_q <= RD_ENDUR;
    end
endmodule

// File: rtl/wp_range_chk.sv
// Module: wp_range_chk
// Builds a per-block protection mask from start and count, then indexes it
// with the block bits of the offered address. The end of the range is
// computed one bit wider so it never wraps past the last block.
module wp_range_chk
    import wp_cfg_pkg::*;
(
    input  logic [BLK_W-1:0]  start_q,
    input  logic [BLK_W-1:0]  count_q,
    input  logic [ADDR_W-1:0] addr,
    output logic              allow
);
    logic [BLK_W:0]       range_end;
    logic [NUM_BLK-1:0]   prot_mask;

    // Exclusive end of the range, one bit wider than a block number.
    always_comb range_end = {1'b0, start_q} + {1'b0, count_q};

    for (genvar i = 0; i < NUM_BLK; i++) begin : g_blk
        // Mark block i when it lies inside [start, end).
        always_comb prot_mask[i] = ((BLK_W+1)'(i) >= {1'b0, start_q}) &&
                                   ((BLK_W+1)'(i) <  range_end);
    end

    // Answer for the addressed block.
    always_comb allow = !prot_mask[addr[ADDR_W-1 -: BLK_W]];
endmodule

// File: rtl/wp_cfg_unit.sv
// Module: wp_cfg_unit (top)
// Write-protect configuration unit: decodes configuration bytes, stores the
// range / endurance settings with a one-time lock, answers per-address
// write permission and supplies readback bytes with an all-ones upper nibble.
module wp_cfg_unit
    import wp_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_vld,
    input  logic [1:0]        cfg_pos,
    input  logic [7:0]        cfg_byte,
    input  logic              rd_idx,
    output logic [7:0]        rd_byte,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              wr_ok,
    output logic [BLK_W-1:0]  he_block,
    output logic              sec_locked
);
    logic [BLK_W-1:0] blk_num, cnt_num;
    logic             do_range_wr, do_endur_wr, do_range_rd, do_endur_rd;
    logic [BLK_W-1:0] prot_start, prot_count;
    rd_mode_t         rd_mode;

    wp_cmd_decode u_dec (
        .clk(clk), .rst_n(rst_n), .cfg_vld(cfg_vld), .cfg_pos(cfg_pos),
        .cfg_byte(cfg_byte), .blk_num(blk_num), .cnt_num(cnt_num),
        .do_range_wr(do_range_wr), .do_endur_wr(do_endur_wr),
        .do_range_rd(do_range_rd), .do_endur_rd(do_endur_rd)
    );

    wp_cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .blk_num(blk_num), .cnt_num(cnt_num),
        .do_range_wr(do_range_wr), .do_endur_wr(do_endur_wr),
        .do_range_rd(do_range_rd), .do_endur_rd(do_endur_rd),
        .start_q(prot_start), .count_q(prot_count), .he_q(he_block),
        .lock_q(sec_locked), .mode_q(rd_mode)
    );

    wp_range_chk u_rng (
        .start_q(prot_start), .count_q(prot_count), .addr(wr_addr), .allow(wr_ok)
    );

    // Readback byte: ones in the upper nibble, selected setting below.
    always_comb begin
        if (rd_mode == RD_ENDUR)
            rd_byte = {4'hF, he_block};
        else if (rd_idx)
            rd_byte = {4'hF, prot_count};
        else
            rd_byte = {4'hF, prot_start};
    end
endmodule

// File: rtl/wp_cfg_unit_chk.sv
// Module: wp_cfg_unit_chk
// Property checker bound into every wp_cfg_unit instance.
module wp_cfg_unit_chk
    import wp_cfg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             locked,
    input logic [BLK_W-1:0] start,
    input logic [BLK_W-1:0] count,
    input logic [BLK_W-1:0] he,
    input logic             wr_ok,
    input logic [7:0]       rd_byte
);
    // R5
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);
    // R5
    range_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> ($stable(start) && $stable(count)));
    // R6
    endur_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(he));
    // R4
    zero_count_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> wr_ok);
    // R3
    range_change_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count) |-> locked);
    // R7
    rd_upper_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_byte[7:4] == 4'hF);
endmodule

bind wp_cfg_unit wp_cfg_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .locked(sec_locked), .start(prot_start),
    .count(prot_count), .he(he_block), .wr_ok(wr_ok), .rd_byte(rd_byte)
);

// File: tb/wp_cfg_unit_test.sv
// Bench: sweeps every start/count pair and probes both ends of every block,
// plus lock, endurance and readback sequences.
module wp_cfg_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_vld = 1'b0;
    logic [1:0]  cfg_pos = '0;
    logic [7:0]  cfg_byte = '0;
    logic        rd_idx = 1'b0;
    logic [7:0]  rd_byte;
    logic [12:0] wr_addr = '0;
    logic        wr_ok;
    logic [3:0]  he_block;
    logic        sec_locked;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    wp_cfg_unit uut (
        .clk(clk), .rst_n(rst_n), .cfg_vld(cfg_vld), .cfg_pos(cfg_pos),
        .cfg_byte(cfg_byte), .rd_idx(rd_idx), .rd_byte(rd_byte),
        .wr_addr(wr_addr), .wr_ok(wr_ok), .he_block(he_block),
        .sec_locked(sec_locked)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic put(input logic [1:0] pos, input logic [7:0] b);
        cfg_vld = 1'b1; cfg_pos = pos; cfg_byte = b;
        @(negedge clk);
        cfg_vld = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
        put(2'd0, b0); put(2'd1, b1); put(2'd2, b2);
    endtask

    task automatic read_range(input string req, input int s, input int c);
        cmd(8'h80, 8'h00, 8'hC0);
        rd_idx = 1'b0; #1; check(req, rd_byte, 8'hF0 | s);
        rd_idx = 1'b1; #1; check(req, rd_byte, 8'hF0 | c);
        rd_idx = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        check("R1", sec_locked, 0);
        check("R1", he_block, 15);
        rd_idx = 1'b0; #1; check("R1", rd_byte, 8'hFF);
        rd_idx = 1'b1; #1; check("R1", rd_byte, 8'hF0);
        for (int a = 0; a < 8192; a += 509) begin
            wr_addr = 13'(a); #1; check("R1", wr_ok, 1);
        end

        // R3 / R4 / R9 sweep of every range
        for (int s = 0; s < 16; s++) begin
            for (int c = 0; c < 16; c++) begin
                do_reset();
                cmd(8'h80 | 8'(s << 1), 8'h5A, 8'h80 | 8'(c));
                check("R3", sec_locked, 1);
                for (int b = 0; b < 16; b++) begin
                    int exp_ok;
                    exp_ok = (b >= s && b < s + c) ? 0 : 1;
                    wr_addr = 13'(b * 512);       #1; check("R4", wr_ok, exp_ok);
                    wr_addr = 13'(b * 512 + 511); #1; check("R9", wr_ok, exp_ok);
                end
            end
        end

        // R2: ignored bits 6,5,0 of byte0 and whole byte1; unmarked byte0 ignored
        do_reset();
        cmd(8'h00 | 8'(3 << 1), 8'h00, 8'h82);          // no marker
        check("R2", sec_locked, 0);
        read_range("R2", 15, 0);
        cmd(8'hE1 | 8'(6 << 1), 8'hFF, 8'hB3);          // bits 5/4 of byte2 ignored too
        check("R2", sec_locked, 1);
        read_range("R2", 6, 3);
        wr_addr = 13'(6 * 512 + 17); #1; check("R2", wr_ok, 0);
        wr_addr = 13'(9 * 512);      #1; check("R2", wr_ok, 1);

        // R3 count 0 still locks
        do_reset();
        cmd(8'h80 | 8'(4 << 1), 8'h00, 8'h80);
        check("R3", sec_locked, 1);
        read_range("R3", 4, 0);

        // R6 endurance set while unlocked, R8 readback
        do_reset();
        cmd(8'h80 | 8'(5 << 1), 8'h00, 8'h00);
        check("R6", he_block, 5);
        cmd(8'h80 | 8'(2 << 1), 8'h00, 8'h00);
        check("R6", he_block, 2);
        cmd(8'h80, 8'h00, 8'h40);
        rd_idx = 1'b0; #1; check("R8", rd_byte, 8'hF2);
        rd_idx = 1'b1; #1; check("R8", rd_byte, 8'hF2);

        // R5 lock then retries; R6 endurance frozen
        cmd(8'h80 | 8'(10 << 1), 8'h00, 8'h82);
        cmd(8'h80 | 8'(1 << 1),  8'h00, 8'h8F);
        check("R5", sec_locked, 1);
        read_range("R5", 10, 2);
        wr_addr = 13'(1 * 512); #1; check("R5", wr_ok, 1);
        wr_addr = 13'(11 * 512 + 3); #1; check("R5", wr_ok, 0);
        cmd(8'h80 | 8'(7 << 1), 8'h00, 8'h00);
        check("R6", he_block, 2);
        cmd(8'h80, 8'h00, 8'h40);
        #1; check("R8", rd_byte, 8'hF2);
        read_range("R7", 10, 2);

        // R9 consecutive bytes across a protected boundary
        wr_addr = 13'(10 * 512 - 1); #1; check("R9", wr_ok, 1);
        wr_addr = 13'(10 * 512);     #1; check("R9", wr_ok, 0);
        wr_addr = 13'(12 * 512 - 1); #1; check("R9", wr_ok, 0);
        wr_addr = 13'(12 * 512);     #1; check("R9", wr_ok, 1);

        done = 1;
    end

    initial begin
        for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule